// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

The block is a first-in first-out buffer for 9-bit words. It is written on one clock and read on another, with the two clocks unrelated. The depth is a power-of-two parameter from 256 to 8192 words. Four active-low status outputs report the fill level:

- empty and almost-empty, which update on the read clock;
- full and almost-full, which update on the write clock.

Each side keeps its own binary pointer. It sends a Gray-coded copy of that pointer to the other side through a two-stage synchroniser.

One input pin, `wr_en2_load`, has two roles, and the block latches which one applies while reset is held.

- **Dual-enable mode.** If the pin is high during reset, it acts as a second write enable, and a write needs both write enables.
- **Programmable mode.** If the pin is low during reset, it becomes a load strobe for four 8-bit threshold registers: empty low byte, empty high byte, full low byte, full high byte.
  - While the strobe is high, each enabled write cycle stores the low byte of the data input into the next register in that fixed order.
  - While the strobe is high, each enabled read cycle puts the next register onto the data output.
  - Each side has its own position in the order, and the position wraps after the fourth register.
  - With the strobe low, the FIFO operates normally.

The empty threshold `n` and the full threshold `m` are built from these registers. Only the pointer-width low bits are used. Almost-empty is asserted while the word count is at most `n`. Almost-full is asserted while the count is at least depth minus `m`.

Top module: `dcf_pflag_fifo`

## Requirements
- R1: With reset held low for several cycles of both clocks, the state after release is as follows. `empty_n`=0, `aempty_n`=0, `full_n`=1, `afull_n`=1, and the data output reads 0 while `out_en`=1.
- R2: The level of `wr_en2_load` while reset is held selects the mode until the next reset: 1 selects dual-enable mode, 0 selects programmable mode. In dual-enable mode a word is written only when `wr_en1`=1 and `wr_en2_load`=1. A cycle with `wr_en1`=1 and `wr_en2_load`=0 stores nothing, and the FIFO stays empty.
- R3: Starting from empty with no reads, `full_n` drops on exactly the depth-th write. Writes attempted while full are ignored, and the stored words are unchanged.
- R4: Words are read in write order. In dual-enable mode a read takes place only when `rd_en1`=1 and `rd_en2`=1, and in programmable mode it also needs `wr_en2_load`=0. The read word appears on `data_out` after the read clock edge. A read cycle with either read enable low leaves `data_out` unchanged. A read while empty also leaves `data_out` unchanged.
- R5: `aempty_n` is 0 while the count is at most the empty threshold `n`, and 1 when the count is above it. After reset `n`=7.
- R6: `afull_n` is 0 while the count is at least depth−`m`, and 1 below that. After reset `m`=7.
- R7: In programmable mode, a write clock cycle with `wr_en2_load`=1 and `wr_en1`=1 stores `data_in[7:0]` into an offset register instead of the FIFO. The registers are taken in the order empty-low, empty-high, full-low, full-high, one per such cycle, wrapping back to empty-low after full-high.
- R8: In programmable mode, a read clock cycle with `wr_en2_load`=1, `rd_en1`=1 and `rd_en2`=1 puts the next offset register onto `data_out`. The registers come out in the same wrapping order as R7. Bit 8 reads 0, and high-byte bits beyond the pointer width read 0. Such a cycle does not pop the FIFO, and it also works while the FIFO is empty.
- R9: While `out_en`=0, `data_out` reads all zeros. Raising `out_en` again shows the held output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, sampled by both clocks |
| wr_en1 | input | 1 | Primary write enable, active high |
| wr_en2_load | input | 1 | Second write enable, or offset load strobe, according to its level during reset |
| data_in | input | 9 | Write data; bits 7:0 also load the offset registers |
| rd_en1 | input | 1 | First read enable, active high |
| rd_en2 | input | 1 | Second read enable, active high |
| out_en | input | 1 | Output enable; when low, the output is forced to zero |
| data_out | output | 9 | Read data or offset register readback |
| empty_n | output | 1 | Low when no word is held (read clock) |
| aempty_n | output | 1 | Low when the count is at most the empty threshold (read clock) |
| full_n | output | 1 | Low when depth words are held (write clock) |
| afull_n | output | 1 | Low when the count is at least depth minus the full threshold (write clock) |

## Verification
The hardest situation to reach is a flag edge that depends on a count seen through the other clock's synchroniser. Examples are almost-empty rising while words are being written, and almost-full falling while words are being read. To reach these, the bench moves the count one word at a time over the whole depth, waits a few cycles of the opposite clock after each step, and then compares every flag against thresholds computed arithmetically. The sweep runs twice: once with the default thresholds, and once after loading new thresholds through the shared strobe pin. Loading the new thresholds also exercises the wrap of the register order and the masking of unused high bits.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;

    localparam int DW    = 9;
    localparam int OFS_W = 8;
    localparam int MAXW  = 14;

    typedef logic [DW-1:0] word_t;

    typedef enum logic [1:0] {
        OFS_E_LO = 2'd0,
        OFS_E_HI = 2'd1,
        OFS_F_LO = 2'd2,
        OFS_F_HI = 2'd3
    } ofs_idx_t;

    typedef struct packed {
        logic [OFS_W-1:0] e_lo;
        logic [OFS_W-1:0] e_hi;
        logic [OFS_W-1:0] f_lo;
        logic [OFS_W-1:0] f_hi;
    } ofs_bank_t;

    function automatic logic [MAXW-1:0] bin2gray(input logic [MAXW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [MAXW-1:0] gray2bin(input logic [MAXW-1:0] g);
        logic [MAXW-1:0] b;
        b[MAXW-1] = g[MAXW-1];
        for (int i = MAXW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic ofs_idx_t ofs_next(input ofs_idx_t idx);
        case (idx)
            OFS_E_LO: return OFS_E_HI;
            OFS_E_HI: return OFS_F_LO;
            OFS_F_LO: return OFS_F_HI;
            default:  return OFS_E_LO;
        endcase
    endfunction

    function automatic logic [2*OFS_W-1:0] ofs_value(input logic [OFS_W-1:0] lo,
                                                     input logic [OFS_W-1:0] hi,
                                                     input int aw);
        logic [2*OFS_W-1:0] mask;
        mask = (16'(1) << aw) - 16'(1);
        return {hi, lo} & mask;
    endfunction

    function automatic logic [OFS_W-1:0] ofs_read(input ofs_bank_t bank,
                                                  input ofs_idx_t idx,
                                                  input int aw);
        logic [OFS_W-1:0] hmask;
        hmask = (8'(1) << (aw - OFS_W)) - 8'(1);
        case (idx)
            OFS_E_LO: return bank.e_lo;
            OFS_E_HI: return bank.e_hi & hmask;
            OFS_F_LO: return bank.f_lo;
            default:  return bank.f_hi & hmask;
        endcase
    endfunction

endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_wr_ctrl.sv
`timescale 1ns/1ps
module dcf_wr_ctrl
    import dcf_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic             wr_clk,
    input  logic             rst,
    input  logic             ld_pin,
    input  logic             wr_en1,
    input  logic [OFS_W-1:0] ofs_din,
    input  logic [PW-1:0]    rgray_s,
    output logic [AW-1:0]    waddr,
    output logic             wr_fire,
    output logic [PW-1:0]    wgray,
    output logic             full,
    output logic             afull,
    output ofs_bank_t        bank,
    output logic [AW-1:0]    e_off
);
    logic          mode_pf;
    logic          wr_req;
    logic          ofs_wr;
    logic [PW-1:0] wbin;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] wcnt;
    logic [PW-1:0] afull_lvl;
    logic [AW-1:0] f_off;
    ofs_idx_t      widx;

    // Mode is captured only while reset is held
    always_ff @(posedge wr_clk) begin
        if (rst) mode_pf <= ~ld_pin;
    end

    assign wr_req  = wr_en1 & (mode_pf ? ~ld_pin : ld_pin);
    assign ofs_wr  = mode_pf & ld_pin & wr_en1;

    assign rbin_s    = PW'(gray2bin(MAXW'(rgray_s)));
    assign wcnt      = wbin - rbin_s;
    assign full      = (wcnt == PW'(DEPTH));
    assign f_off     = AW'(ofs_value(bank.f_lo, bank.f_hi, AW));
    assign e_off     = AW'(ofs_value(bank.e_lo, bank.e_hi, AW));
    assign afull_lvl = PW'(DEPTH) - PW'(f_off);
    assign afull     = (wcnt >= afull_lvl);
    assign wr_fire   = wr_req & ~full;
    assign waddr     = wbin[AW-1:0];

    always_ff @(posedge wr_clk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_fire) begin
            wbin  <= wbin + PW'(1);
            wgray <= PW'(bin2gray(MAXW'(wbin + PW'(1))));
        end
    end

    always_ff @(posedge wr_clk) begin
        if (rst) begin
            bank.e_lo <= 8'd7;
            bank.e_hi <= 8'd0;
            bank.f_lo <= 8'd7;
            bank.f_hi <= 8'd0;
            widx      <= OFS_E_LO;
        end else if (ofs_wr) begin
            case (widx)
                OFS_E_LO: bank.e_lo <= ofs_din;
                OFS_E_HI: bank.e_hi <= ofs_din;
                OFS_F_LO: bank.f_lo <= ofs_din;
                default:  bank.f_hi <= ofs_din;
            endcase
            widx <= ofs_next(widx);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (rst)
        wcnt <= PW'(DEPTH)); // R3
    AST_FULL_BLOCKS: assert property (@(posedge wr_clk) disable iff (rst)
        (full && wr_req) |=> $stable(wbin)); // R3
    AST_AFULL_COVERS_FULL: assert property (@(posedge wr_clk) disable iff (rst)
        full |-> afull); // R6
    AST_MODE_HELD: assert property (@(posedge wr_clk) disable iff (rst)
        1'b1 |=> $stable(mode_pf)); // R2
endmodule

// File: rtl/dcf_rd_ctrl.sv
`timescale 1ns/1ps
module dcf_rd_ctrl
    import dcf_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          rd_clk,
    input  logic          rst,
    input  logic          ld_pin,
    input  logic          rd_en1,
    input  logic          rd_en2,
    input  logic [PW-1:0] wgray_s,
    input  logic [AW-1:0] e_off,
    output logic [AW-1:0] raddr,
    output logic          rd_fire,
    output logic          ofs_rd,
    output ofs_idx_t      ridx,
    output logic          empty,
    output logic          aempty,
    output logic [PW-1:0] rgray
);
    logic          mode_pf;
    logic          rd_req;
    logic          both_en;
    logic [PW-1:0] rbin;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] rcnt;

    always_ff @(posedge rd_clk) begin
        if (rst) mode_pf <= ~ld_pin;
    end

    assign both_en = rd_en1 & rd_en2;
    assign rd_req  = both_en & ~(mode_pf & ld_pin);
    assign ofs_rd  = both_en & mode_pf & ld_pin;

    assign wbin_s  = PW'(gray2bin(MAXW'(wgray_s)));
    assign rcnt    = wbin_s - rbin;
    assign empty   = (rcnt == '0);
    assign aempty  = (rcnt <= PW'(e_off));
    assign rd_fire = rd_req & ~empty;
    assign raddr   = rbin[AW-1:0];

    always_ff @(posedge rd_clk) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (rd_fire) begin
            rbin  <= rbin + PW'(1);
            rgray <= PW'(bin2gray(MAXW'(rbin + PW'(1))));
        end
    end

    always_ff @(posedge rd_clk) begin
        if (rst)         ridx <= OFS_E_LO;
        else if (ofs_rd) ridx <= ofs_next(ridx);
    end

    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (rst)
        rcnt <= PW'(DEPTH)); // R4
    AST_EMPTY_BLOCKS: assert property (@(posedge rd_clk) disable iff (rst)
        (empty && rd_req) |=> $stable(rbin)); // R4
    AST_AEMPTY_COVERS_EMPTY: assert property (@(posedge rd_clk) disable iff (rst)
        empty |-> aempty); // R5
    AST_OFS_READ_NO_POP: assert property (@(posedge rd_clk) disable iff (rst)
        ofs_rd |=> $stable(rbin)); // R8
endmodule

// File: rtl/dcf_pflag_fifo.sv
`timescale 1ns/1ps
module dcf_pflag_fifo
    import dcf_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wr_en1,
    input  logic          wr_en2_load,
    input  logic [DW-1:0] data_in,
    input  logic          rd_en1,
    input  logic          rd_en2,
    input  logic          out_en,
    output logic [DW-1:0] data_out,
    output logic          empty_n,
    output logic          aempty_n,
    output logic          full_n,
    output logic          afull_n
);
    logic          rst;
    logic [AW-1:0] waddr, raddr;
    logic          wr_fire, rd_fire, ofs_rd;
    logic [PW-1:0] wgray, wgray_s, rgray, rgray_s;
    logic          full, afull, empty, aempty;
    ofs_bank_t     bank;
    logic [AW-1:0] e_off;
    ofs_idx_t      ridx;
    word_t         mem [DEPTH];
    word_t         data_q;
    word_t         ofs_word;

    assign rst = ~rst_n;

    dcf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .wr_clk  (wr_clk),
        .rst     (rst),
        .ld_pin  (wr_en2_load),
        .wr_en1  (wr_en1),
        .ofs_din (data_in[OFS_W-1:0]),
        .rgray_s (rgray_s),
        .waddr   (waddr),
        .wr_fire (wr_fire),
        .wgray   (wgray),
        .full    (full),
        .afull   (afull),
        .bank    (bank),
        .e_off   (e_off)
    );

    dcf_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .rd_clk  (rd_clk),
        .rst     (rst),
        .ld_pin  (wr_en2_load),
        .rd_en1  (rd_en1),
        .rd_en2  (rd_en2),
        .wgray_s (wgray_s),
        .e_off   (e_off),
        .raddr   (raddr),
        .rd_fire (rd_fire),
        .ofs_rd  (ofs_rd),
        .ridx    (ridx),
        .empty   (empty),
        .aempty  (aempty),
        .rgray   (rgray)
    );

    dcf_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst(rst), .d(wgray), .q(wgray_s));
    dcf_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst(rst), .d(rgray), .q(rgray_s));

    always_ff @(posedge wr_clk) begin
        if (wr_fire) mem[waddr] <= data_in;
    end

    assign ofs_word = {1'b0, ofs_read(bank, ridx, AW)};

    always_ff @(posedge rd_clk) begin
        if (rst)          data_q <= '0;
        else if (rd_fire) data_q <= mem[raddr];
        else if (ofs_rd)  data_q <= ofs_word;
    end

    assign data_out = out_en ? data_q : '0;
    assign empty_n  = ~empty;
    assign aempty_n = ~aempty;
    assign full_n   = ~full;
    assign afull_n  = ~afull;

    AST_EMPTY_READ_HOLDS: assert property (@(posedge rd_clk) disable iff (rst)
        (empty && rd_en1 && rd_en2 && !ofs_rd) |=> $stable(data_q)); // R4
    AST_GATED_READ_HOLDS: assert property (@(posedge rd_clk) disable iff (rst)
        (!(rd_en1 && rd_en2)) |=> $stable(data_q)); // R4
endmodule

// File: tb/tb_dcf_pflag_fifo.sv
`timescale 1ns/1ps
module tb_dcf_pflag_fifo;
    localparam int DEPTH = 256;

    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en1 = 1'b0;
    logic       wr_en2_load = 1'b1;
    logic [8:0] data_in = '0;
    logic       rd_en1 = 1'b0;
    logic       rd_en2 = 1'b0;
    logic       out_en = 1'b1;
    logic [8:0] data_out;
    logic       empty_n, aempty_n, full_n, afull_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    dcf_pflag_fifo #(.DEPTH(DEPTH)) dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_en1(wr_en1), .wr_en2_load(wr_en2_load), .data_in(data_in),
        .rd_en1(rd_en1), .rd_en2(rd_en2), .out_en(out_en),
        .data_out(data_out), .empty_n(empty_n), .aempty_n(aempty_n),
        .full_n(full_n), .afull_n(afull_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [8:0] pat(input int j, input int salt);
        return 9'((j * 37 + salt) & 9'h1FF);
    endfunction

    task automatic do_reset(input logic pin);
        wr_en2_load = pin;
        rst_n = 1'b0;
        repeat (6) @(negedge wr_clk);
        repeat (6) @(negedge rd_clk);
        @(negedge wr_clk);
        rst_n = 1'b1;
        repeat (3) @(negedge wr_clk);
    endtask

    task automatic push(input logic [8:0] d);
        @(negedge wr_clk);
        wr_en1  = 1'b1;
        data_in = d;
        @(negedge wr_clk);
        wr_en1  = 1'b0;
    endtask

    task automatic pop_g(input logic e1, input logic e2);
        @(negedge rd_clk);
        rd_en1 = e1;
        rd_en2 = e2;
        @(negedge rd_clk);
        rd_en1 = 1'b0;
        rd_en2 = 1'b0;
    endtask

    task automatic settle_rd();
        repeat (5) @(negedge rd_clk);
    endtask

    task automatic settle_wr();
        repeat (5) @(negedge wr_clk);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // ---------- dual-enable mode ----------
        do_reset(1'b1);
        settle_rd();
        chk("R1 empty_n", empty_n, 0);
        chk("R1 aempty_n", aempty_n, 0);
        chk("R1 full_n", full_n, 1);
        chk("R1 afull_n", afull_n, 1);
        chk("R1 data_out", data_out, 0);

        // R2: second enable low blocks the write
        wr_en2_load = 1'b0;
        push(9'h011);
        wr_en2_load = 1'b1;
        settle_rd();
        chk("R2 blocked write empty_n", empty_n, 0);

        // fill sweep with default thresholds
        for (int k = 1; k <= DEPTH; k++) begin
            push(pat(k - 1, 5));
            chk("R3 full_n fill", full_n, (k == DEPTH) ? 0 : 1);
            chk("R6 afull_n fill", afull_n, (k >= DEPTH - 7) ? 0 : 1);
            settle_rd();
            chk("R5 aempty_n fill", aempty_n, (k <= 7) ? 0 : 1);
            chk("R4 empty_n fill", empty_n, 1);
        end
        push(9'h1FF);
        chk("R3 full_n after extra write", full_n, 0);

        // drain sweep
        for (int j = 0; j < DEPTH; j++) begin
            int cnt;
            cnt = DEPTH - 1 - j;
            pop_g(1'b1, 1'b1);
            chk("R4 data order", data_out, pat(j, 5));
            chk("R5 aempty_n drain", aempty_n, (cnt <= 7) ? 0 : 1);
            chk("R4 empty_n drain", empty_n, (cnt == 0) ? 0 : 1);
            settle_wr();
            chk("R3 full_n drain", full_n, 1);
            chk("R6 afull_n drain", afull_n, (cnt >= DEPTH - 7) ? 0 : 1);
        end
        pop_g(1'b1, 1'b1);
        chk("R4 read while empty holds", data_out, pat(DEPTH - 1, 5));

        // read-enable gating
        push(9'h0AA);
        push(9'h155);
        settle_rd();
        pop_g(1'b1, 1'b0);
        chk("R4 rd_en2 low holds", data_out, pat(DEPTH - 1, 5));
        pop_g(1'b0, 1'b1);
        chk("R4 rd_en1 low holds", data_out, pat(DEPTH - 1, 5));
        pop_g(1'b1, 1'b1);
        chk("R4 gated pop first", data_out, 9'h0AA);
        pop_g(1'b1, 1'b1);
        chk("R4 gated pop second", data_out, 9'h155);

        // output enable
        @(negedge rd_clk);
        out_en = 1'b0;
        #1;
        chk("R9 out_en low zero", data_out, 0);
        out_en = 1'b1;
        #1;
        chk("R9 out_en restore", data_out, 9'h155);

        // ---------- programmable mode ----------
        do_reset(1'b0);
        settle_rd();
        chk("R1 prog empty_n", empty_n, 0);
        chk("R1 prog full_n", full_n, 1);
        chk("R1 prog data_out", data_out, 0);

        wr_en2_load = 1'b1;
        pop_g(1'b1, 1'b1);
        chk("R8 default e_lo", data_out, 7);
        pop_g(1'b1, 1'b1);
        chk("R8 default e_hi", data_out, 0);
        pop_g(1'b1, 1'b1);
        chk("R8 default f_lo", data_out, 7);
        pop_g(1'b1, 1'b1);
        chk("R8 default f_hi", data_out, 0);

        push(9'h103);
        push(9'h0FF);
        push(9'h114);
        push(9'h0AB);
        settle_rd();
        chk("R7 offset writes not stored", empty_n, 0);
        pop_g(1'b1, 1'b1);
        chk("R8 e_lo readback bit8 clear", data_out, 3);
        pop_g(1'b1, 1'b1);
        chk("R8 e_hi masked", data_out, 0);
        pop_g(1'b1, 1'b1);
        chk("R7 f_lo written", data_out, 20);
        pop_g(1'b1, 1'b1);
        chk("R8 f_hi masked", data_out, 0);
        push(9'h005);
        pop_g(1'b1, 1'b1);
        chk("R7 write order wraps to e_lo", data_out, 5);

        wr_en2_load = 1'b0;
        settle_wr();
        for (int k = 1; k <= DEPTH; k++) begin
            push(pat(k - 1, 11));
            chk("R6 afull_n prog fill", afull_n, (k >= DEPTH - 20) ? 0 : 1);
            chk("R3 full_n prog fill", full_n, (k == DEPTH) ? 0 : 1);
            settle_rd();
            chk("R5 aempty_n prog fill", aempty_n, (k <= 5) ? 0 : 1);
        end
        for (int j = 0; j < DEPTH; j++) begin
            int cnt;
            cnt = DEPTH - 1 - j;
            pop_g(1'b1, 1'b1);
            chk("R4 prog data order", data_out, pat(j, 11));
            chk("R5 aempty_n prog drain", aempty_n, (cnt <= 5) ? 0 : 1);
        end
        settle_wr();
        chk("R6 afull_n prog empty", afull_n, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule